// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers up to fifteen interrupt lines, numbered 1 to 15, and presents them to a small group of processors. A rising edge on an input line sets a bit in a shared pending word. Software can also set pending bits through a global force word, and it can drop them through a clear word. Each processor owns two private words. The first is an enable mask. The second is a force word, which raises interrupts for that processor alone.

For every processor the controller drives a 4-bit level. This is the number of the interrupt it should take next. An interrupt is eligible for a processor when its bit is set in the pending word or in that processor's force word, and also in that processor's mask. Among the eligible interrupts, those picked out by a shared priority-select word are served first. Within a group, the larger number wins.

When a processor acknowledges level L, the controller removes that interrupt for it. If the processor's private force bit L is set, that bit is cleared. Otherwise shared pending bit L is cleared.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset, every pending, force, mask and priority-select bit is 0 and every processor level output is 0. Reading word 4 returns the processor count NCPU.
- R2: Bit 0 of every word is unused. Writes to it have no effect and it reads as 0.
- R3: A 0-to-1 transition on irq_in[n] (n = 1..15) sets pending bit n one clock later. A line held high does not set the bit again after it has been cleared.
- R4: Writing word 2 (global force) sets the pending bits written as 1 and leaves the others alone. Reading word 2 returns 0. Reading word 1 returns the pending word.
- R5: Writing word 3 (clear) drops each pending bit written as 1, and zero bits have no effect. A new edge or a global force on the same bit in the same cycle wins over the clear.
- R6: Word 16+i is the enable mask of processor i. A 1 enables that source for processor i and a 0 blocks it.
- R7: Processor i's level is the largest n whose bit is set in (pending OR force_i) AND mask_i, or 0 if no bit is set. Level bits [4i+3:4i] belong to processor i.
- R8: Word 0 is the priority select. If any eligible source has its select bit set, the level is the largest such source, even when a larger unselected source is eligible.
- R9: Word 32+i is processor i's private force word. It makes a source eligible for processor i only, and it does not alter the pending word.
- R10: An acknowledge from processor i with level L (1..15) clears force_i bit L if that bit is set. Otherwise it clears pending bit L. An acknowledge with level 0 changes nothing.
- R11: If a write to force word 32+i and an acknowledge from processor i happen in the same cycle, the written value is stored. In that case an acknowledge aimed at the force bit leaves the pending word untouched.
- R12: Unmapped words, and mask or force words of processors at or above NCPU, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines; bit n is source n, bit 0 ignored |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Word address of the combinational read |
| rd_data | output | 16 | Read data |
| ack_vld | input | NCPU | Per-processor acknowledge strobe |
| ack_lvl | input | 4*NCPU | Acknowledged level, 4 bits per processor |
| cpu_lvl | output | 4*NCPU | Requested level, 4 bits per processor |

## Verification
The bench builds the controller with NCPU = 2. With this count the two processors can be given different masks and private forces, and word 18 falls outside the populated processor range, so R12 can be exercised. Every level from 1 to 15 is swept one at a time. Several hundred generated combinations of pending, mask and priority-select words are then compared with a bench-side priority model for both processors, covering the grouped ordering of R8. Directed sequences cover the same-cycle races: an edge against a clear, and a force-word write against an acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned ADDR_W  = 6;

  localparam int unsigned OFS_PRIO   = 0;
  localparam int unsigned OFS_PEND   = 1;
  localparam int unsigned OFS_GFORCE = 2;
  localparam int unsigned OFS_CLEAR  = 3;
  localparam int unsigned OFS_MPSTAT = 4;
  localparam int unsigned OFS_MASK0  = 16;
  localparam int unsigned OFS_FRC0   = 32;

  localparam logic [WORD_W-1:0] SRC_BITS = 16'hFFFE;

  // Index of the most significant set bit among bits 1..15, 0 when none.
  function automatic logic [LVL_W-1:0] top_bit(input logic [WORD_W-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int n = 1; n < WORD_W; n++) begin
      if (v[n]) r = LVL_W'(n);
    end
    return r;
  endfunction

  // Selected sources are served first, then plain numeric order.
  function automatic logic [LVL_W-1:0] pick_level(input logic [WORD_W-1:0] elig,
                                                  input logic [WORD_W-1:0] sel);
    logic [WORD_W-1:0] hi;
    hi = elig & sel & SRC_BITS;
    if (hi != '0) return top_bit(hi);
    return top_bit(elig & SRC_BITS);
  endfunction

  function automatic logic [WORD_W-1:0] lvl_onehot(input logic [LVL_W-1:0] l);
    if (l == '0) return '0;
    return WORD_W'(1) << l;
  endfunction
endpackage

// File: rtl/irqc_pend_unit.sv
module irqc_pend_unit
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] irq_in,
  input  logic              gforce_we,
  input  logic              clear_we,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] ack_clr,
  output logic [WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0] set_evt
);
  logic [WORD_W-1:0] line_prev_q;
  logic [WORD_W-1:0] rise;
  logic [WORD_W-1:0] drop;

  always_comb begin
    rise    = irq_in & ~line_prev_q;
    set_evt = (rise | (gforce_we ? wr_data : '0)) & SRC_BITS;
    drop    = (clear_we ? wr_data : '0) | ack_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_prev_q <= '0;
      pend_q      <= '0;
    end else begin
      line_prev_q <= irq_in;
      pend_q      <= ((pend_q & ~drop) | set_evt) & SRC_BITS;
    end
  end
endmodule

// File: rtl/irqc_cpu_slice.sv
module irqc_cpu_slice
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              frc_we,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] pend_q,
  input  logic [WORD_W-1:0] prio_sel,
  input  logic              ack_vld,
  input  logic [LVL_W-1:0]  ack_lvl,
  output logic [LVL_W-1:0]  lvl,
  output logic [WORD_W-1:0] pend_clr,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] frc_q
);
  logic [WORD_W-1:0] ack_vec;
  logic [WORD_W-1:0] frc_hit;

  always_comb begin
    ack_vec  = ack_vld ? lvl_onehot(ack_lvl) : '0;
    frc_hit  = ack_vec & frc_q;
    pend_clr = ack_vec & ~frc_q;
    lvl      = pick_level((pend_q | frc_q) & mask_q, prio_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      frc_q  <= '0;
    end else begin
      if (mask_we) mask_q <= wr_data & SRC_BITS;
      if (frc_we) frc_q <= wr_data & SRC_BITS;
      else        frc_q <= frc_q & ~frc_hit;
    end
  end
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NCPU = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             irq_in,
  input  logic                    wr_en,
  input  logic [5:0]              wr_addr,
  input  logic [15:0]             wr_data,
  input  logic [5:0]              rd_addr,
  output logic [15:0]             rd_data,
  input  logic [NCPU-1:0]         ack_vld,
  input  logic [NCPU*4-1:0]       ack_lvl,
  output logic [NCPU*4-1:0]       cpu_lvl
);
  localparam int unsigned FLAT_W = NCPU * WORD_W;

  logic [WORD_W-1:0] prio_q;
  logic [WORD_W-1:0] pend_q;
  logic [WORD_W-1:0] set_evt;
  logic [WORD_W-1:0] ack_pend_clr;
  logic [WORD_W-1:0] mask_w [NCPU];
  logic [WORD_W-1:0] frc_w  [NCPU];
  logic [WORD_W-1:0] pclr_w [NCPU];
  logic [FLAT_W-1:0] mask_flat;
  logic [FLAT_W-1:0] frc_flat;
  logic              gforce_we;
  logic              clear_we;
  logic              prio_we;

  assign gforce_we = wr_en && (wr_addr == ADDR_W'(OFS_GFORCE));
  assign clear_we  = wr_en && (wr_addr == ADDR_W'(OFS_CLEAR));
  assign prio_we   = wr_en && (wr_addr == ADDR_W'(OFS_PRIO));

  always_ff @(posedge clk) begin
    if (!rst_n)       prio_q <= '0;
    else if (prio_we) prio_q <= wr_data & SRC_BITS;
  end

  irqc_pend_unit u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .gforce_we(gforce_we),
    .clear_we (clear_we),
    .wr_data  (wr_data),
    .ack_clr  (ack_pend_clr),
    .pend_q   (pend_q),
    .set_evt  (set_evt)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    irqc_cpu_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (wr_en && (wr_addr == ADDR_W'(OFS_MASK0 + i))),
      .frc_we  (wr_en && (wr_addr == ADDR_W'(OFS_FRC0 + i))),
      .wr_data (wr_data),
      .pend_q  (pend_q),
      .prio_sel(prio_q),
      .ack_vld (ack_vld[i]),
      .ack_lvl (ack_lvl[i*LVL_W +: LVL_W]),
      .lvl     (cpu_lvl[i*LVL_W +: LVL_W]),
      .pend_clr(pclr_w[i]),
      .mask_q  (mask_w[i]),
      .frc_q   (frc_w[i])
    );
    assign mask_flat[i*WORD_W +: WORD_W] = mask_w[i];
    assign frc_flat[i*WORD_W +: WORD_W]  = frc_w[i];
  end

  always_comb begin
    ack_pend_clr = '0;
    for (int i = 0; i < NCPU; i++) ack_pend_clr = ack_pend_clr | pclr_w[i];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(OFS_PRIO):   rd_data = prio_q;
      ADDR_W'(OFS_PEND):   rd_data = pend_q;
      ADDR_W'(OFS_MPSTAT): rd_data = WORD_W'(NCPU);
      default:             rd_data = '0;
    endcase
    for (int i = 0; i < NCPU; i++) begin
      if (rd_addr == ADDR_W'(OFS_MASK0 + i)) rd_data = mask_w[i];
      if (rd_addr == ADDR_W'(OFS_FRC0 + i))  rd_data = frc_w[i];
    end
  end
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks
  import irqc_pkg::*;
#(
  parameter int unsigned NCPU = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [15:0]            pend_q,
  input logic [15:0]            set_evt,
  input logic                   wr_en,
  input logic [5:0]             wr_addr,
  input logic [15:0]            wr_data,
  input logic [NCPU-1:0]        ack_vld,
  input logic [NCPU*4-1:0]      ack_lvl,
  input logic [NCPU*4-1:0]      cpu_lvl,
  input logic [NCPU*16-1:0]     mask_flat,
  input logic [NCPU*16-1:0]     frc_flat
);
  logic clear_wr;
  assign clear_wr = wr_en && (wr_addr == 6'(OFS_CLEAR));

  AST_PEND_BIT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] == 1'b0); // R2

  AST_SET_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((pend_q & $past(set_evt)) == $past(set_evt))); // R3

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && ((wr_data & set_evt) == '0)) |=> ((pend_q & $past(wr_data)) == '0)); // R5

  for (genvar i = 0; i < NCPU; i++) begin : g_chk
    logic [15:0] elig;
    logic [15:0] lvl_bit;
    logic [15:0] ack_bit;
    logic        frc_wr;
    assign elig    = (pend_q | frc_flat[i*16 +: 16]) & mask_flat[i*16 +: 16];
    assign lvl_bit = 16'(1) << cpu_lvl[i*4 +: 4];
    assign ack_bit = (ack_lvl[i*4 +: 4] == 4'd0) ? 16'd0 : (16'(1) << ack_lvl[i*4 +: 4]);
    assign frc_wr  = wr_en && (wr_addr == 6'(OFS_FRC0 + i));

    AST_LEVEL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_lvl[i*4 +: 4] != 4'd0) |-> ((elig & lvl_bit) != '0)); // R7

    AST_LEVEL_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == '0) |-> (cpu_lvl[i*4 +: 4] == 4'd0)); // R7

    AST_ACK_DROPS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld[i] && !frc_wr && ((frc_flat[i*16 +: 16] & ack_bit) != '0))
        |=> ((frc_flat[i*16 +: 16] & $past(ack_bit)) == '0)); // R10
  end
endmodule

bind mp_irq_ctrl irqc_checks #(.NCPU(NCPU)) u_irqc_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .pend_q   (pend_q),
  .set_evt  (set_evt),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .ack_vld  (ack_vld),
  .ack_lvl  (ack_lvl),
  .cpu_lvl  (cpu_lvl),
  .mask_flat(mask_flat),
  .frc_flat (frc_flat)
);

// File: tb/mp_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mp_irq_ctrl_bench;
  localparam int NCPU = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      irq_in = '0;
  logic             wr_en = 1'b0;
  logic [5:0]       wr_addr = '0;
  logic [15:0]      wr_data = '0;
  logic [5:0]       rd_addr = '0;
  logic [15:0]      rd_data;
  logic [NCPU-1:0]  ack_vld = '0;
  logic [NCPU*4-1:0] ack_lvl = '0;
  logic [NCPU*4-1:0] cpu_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mp_irq_ctrl #(.NCPU(NCPU)) u_mp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ack_vld(ack_vld),
    .ack_lvl(ack_lvl), .cpu_lvl(cpu_lvl)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input int a, input logic [15:0] d,
                      input logic [NCPU-1:0] av, input logic [NCPU*4-1:0] al);
    @(negedge clk);
    wr_en = we; wr_addr = 6'(a); wr_data = d; ack_vld = av; ack_lvl = al;
    @(negedge clk);
    wr_en = 1'b0; ack_vld = '0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    step(1'b1, a, d, '0, '0);
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    rd_addr = 6'(a);
    #0.5;
    v = rd_data;
  endtask

  task automatic chk_rd(input string req, input int a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // Bench priority model: scan the selected group from the top, then everything.
  function automatic logic [3:0] model_lvl(input logic [15:0] el, input logic [15:0] sel);
    for (int n = 15; n >= 1; n--) if (el[n] && sel[n]) return 4'(n);
    for (int n = 15; n >= 1; n--) if (el[n]) return 4'(n);
    return 4'd0;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed;
    logic [15:0] p, m0, m1, hs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd("R1 prio", 0, 16'h0);
    chk_rd("R1 pend", 1, 16'h0);
    chk_rd("R1 mask0", 16, 16'h0);
    chk_rd("R1 frc1", 33, 16'h0);
    chk_rd("R1 mpstat", 4, 16'd2);
    chk("R1 levels", 16'(cpu_lvl), 16'h0);

    // R2 bit 0 ignored, R4 global force readback
    wr(2, 16'hFFFF); wr(16, 16'hFFFF); wr(32, 16'hFFFF); wr(0, 16'hFFFF);
    chk_rd("R2 pend", 1, 16'hFFFE);
    chk_rd("R2 mask", 16, 16'hFFFE);
    chk_rd("R2 frc", 32, 16'hFFFE);
    chk_rd("R2 prio", 0, 16'hFFFE);
    chk_rd("R4 gforce reads 0", 2, 16'h0);
    wr(3, 16'hFFFF); wr(32, 16'h0); wr(0, 16'h0);
    chk_rd("R5 clear all", 1, 16'h0);

    // R12 unpopulated processor word
    wr(18, 16'hFFFF); wr(34, 16'hFFFF); wr(2, 16'h0010);
    chk_rd("R12 mask2", 18, 16'h0);
    chk_rd("R12 frc2", 34, 16'h0);
    chk_rd("R12 unmapped", 5, 16'h0);
    chk("R12 no effect on cpu0", 16'(cpu_lvl[3:0]), 16'd4);
    wr(3, 16'hFFFF);

    // R6/R7 single-level sweep
    wr(17, 16'h0);
    for (int n = 1; n < 16; n++) begin
      wr(3, 16'hFFFF);
      wr(2, 16'(1) << n);
      chk("R7 single cpu0", 16'(cpu_lvl[3:0]), 16'(n));
      chk("R6 masked cpu1", 16'(cpu_lvl[7:4]), 16'd0);
    end

    // R4/R7/R8 generated patterns
    seed = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      seed = nxt(seed); p  = seed[15:0];
      seed = nxt(seed); m0 = seed[15:0]; m1 = seed[31:16];
      seed = nxt(seed); hs = (k % 4 == 0) ? 16'h0 : (seed[15:0] & seed[31:16]);
      wr(3, 16'hFFFF); wr(2, p); wr(16, m0); wr(17, m1); wr(0, hs);
      chk_rd("R4 pend", 1, p & 16'hFFFE);
      chk("R8 cpu0", 16'(cpu_lvl[3:0]), 16'(model_lvl(p & m0 & 16'hFFFE, hs)));
      chk("R8 cpu1", 16'(cpu_lvl[7:4]), 16'(model_lvl(p & m1 & 16'hFFFE, hs)));
    end
    wr(0, 16'h0); wr(3, 16'hFFFF);
    wr(16, 16'hFFFE); wr(17, 16'hFFFE);

    // R9 private force
    wr(33, 16'h0200);
    chk("R9 cpu1", 16'(cpu_lvl[7:4]), 16'd9);
    chk("R9 cpu0", 16'(cpu_lvl[3:0]), 16'd0);
    chk_rd("R9 pend untouched", 1, 16'h0);

    // R10 acknowledge order
    wr(2, 16'h0200);
    step(1'b0, 0, 16'h0, 2'b10, 8'h90);
    chk_rd("R10 frc cleared", 33, 16'h0);
    chk_rd("R10 pend kept", 1, 16'h0200);
    step(1'b0, 0, 16'h0, 2'b10, 8'h00);
    chk_rd("R10 ack 0 no effect", 1, 16'h0200);
    step(1'b0, 0, 16'h0, 2'b10, 8'h90);
    chk_rd("R10 pend cleared", 1, 16'h0);
    chk("R10 level idle", 16'(cpu_lvl), 16'h0);

    // R11 write wins over acknowledge
    wr(33, 16'h8000); wr(2, 16'h8000);
    step(1'b1, 33, 16'h8000, 2'b10, 8'hF0);
    chk_rd("R11 frc kept", 33, 16'h8000);
    chk_rd("R11 pend kept", 1, 16'h8000);
    wr(33, 16'h0); wr(3, 16'hFFFF);

    // R3 edge capture
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk);
    chk_rd("R3 rise sets", 1, 16'h0020);
    wr(3, 16'h0020);
    repeat (2) @(negedge clk);
    chk_rd("R3 held high no reset", 1, 16'h0);
    irq_in[5] = 1'b0;
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk);
    chk_rd("R3 second rise", 1, 16'h0020);
    irq_in[5] = 1'b0;

    // R5 edge beats clear, zero bits no effect
    @(negedge clk);
    irq_in[6] = 1'b1; wr_en = 1'b1; wr_addr = 6'd3; wr_data = 16'h0040;
    @(negedge clk);
    wr_en = 1'b0;
    chk_rd("R5 set wins", 1, 16'h0060);
    wr(3, 16'h0000);
    chk_rd("R5 zero clear", 1, 16'h0060);
    wr(3, 16'h0020);
    chk_rd("R5 one clear", 1, 16'h0040);
    irq_in = '0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule